// File: doc/BRIEF.md
# Chipset Control Register Bank

This block holds the control and status words of a system chipset behind a simple memory-mapped bus. Every register is 32 bits wide, but the bus may access it as a byte, a halfword or a whole word. A narrow write is merged into the addressed word: the unselected lanes keep their old contents. A narrow read returns the selected lane, zero-extended.

The bank holds several scalar registers: a global configuration word, translation-table base and limit, read-only fault-capture words, I/O cache tags, a cache byte mask and a cache buffer window, and a nonvolatile-memory protect word. It also holds two arrays: a set of remote-speed words and a per-channel DMA descriptor array. The cache byte mask behaves differently from the others. A write sets bits in it and never clears them. Decoding covers a 0x300-byte window. Any offset that does not decode reads as zero and drops writes. The bank only stores and returns values. Whatever consumes these settings lives elsewhere.

A request is presented for one cycle with `bus_valid`. A write takes effect at that clock edge. A read answers one cycle later with `rsp_valid` and `rsp_rdata`.

Top module: `chipreg_bank`

## Requirements
- R1: After synchronous active-low reset, the configuration word reads 0x0000_0104 and the protect word reads 0x0000_0007. Every other register, including every remote-speed and DMA word, reads 0.
- R2: A read request accepted at a clock edge gives `rsp_valid` high with the read data in the following cycle. A write accepted at an edge is visible to any later read.
- R3: The scalar registers are decoded by word at these byte offsets, each read/write unless R10 or R11 says otherwise:
  - configuration at 0x000
  - translation base at 0x018
  - translation limit at 0x020
  - cache physical tag at 0x048
  - cache logical tag at 0x050
  - cache byte mask at 0x058
  - buffer window at 0x060
  - protect word at 0x220
- R4: Fifteen remote-speed words sit at 0x070 + 8*k for k = 0..14. Each is separately read/write.
- R5: The DMA array has 8 channels of 4 words. Channel c, word r sits at 0x100 + 32*c + 8*r. Each word is separately read/write.
- R6: `bus_size` selects the access width: 0 is byte, 1 is halfword, 2 or 3 is word. A byte read returns lane `bus_addr[1:0]` of the word, that is bits [8*lane+7 : 8*lane], in `rsp_rdata[7:0]`, with bits 31:8 zero.
- R7: A halfword read returns bits 31:16 when `bus_addr[1]` is 1 and bits 15:0 when it is 0. The half appears in `rsp_rdata[15:0]` with bits 31:16 zero. `bus_addr[0]` is ignored.
- R8: A byte write puts `bus_wdata[7:0]` into lane `bus_addr[1:0]` and leaves the other three lanes unchanged.
- R9: A halfword write puts `bus_wdata[15:0]` into bits 31:16 when `bus_addr[1]` is 1, and into bits 15:0 otherwise. The other half is unchanged and `bus_wdata[31:16]` is ignored.
- R10: A write to the cache byte mask ORs the lane-positioned write data into its current value. A write can set bits in the mask but never clears any.
- R11: The invalid-address word (0x010), remote-fault word (0x038) and memory-fault word (0x040) always read 0 and ignore writes.
- R12: Undecoded offsets read 0 and discard writes, leaving every register unchanged. These include gaps between registers, the odd words inside the stride-8 arrays, and any offset at or above 0x300.
- R13: `rsp_valid` is low in every cycle that does not follow an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Byte offset in the window |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data, right-aligned for narrow writes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, zero-extended for narrow reads |

## Verification
Internal state in this block is only visible when it is read back, so a fault shows at the ports one cycle after the next read of the affected word. A wrong slot index or stride shows up as a value appearing at a neighbouring offset. A bad merge mask shows up as a corrupted untouched lane after a narrow write. A mask register that replaces instead of accumulating loses previously set bits on the next readback. Reset faults appear on the very first read after reset is released.

// File: rtl/chipreg_pkg.sv
// Package: shared constants and types for the chipset register bank.
// Holds the access-size encoding, the fixed scalar slot numbers, the
// scalar byte offsets and the per-slot reset value function.
package chipreg_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD3 = 2'd3
    } acc_size_e;

    // Fixed scalar slots; arrays follow after SLOT_SCALARS.
    localparam int SLOT_CFG     = 0;
    localparam int SLOT_BADADDR = 1;
    localparam int SLOT_XBASE   = 2;
    localparam int SLOT_XLIMIT  = 3;
    localparam int SLOT_RFAULT  = 4;
    localparam int SLOT_MFAULT  = 5;
    localparam int SLOT_PTAG    = 6;
    localparam int SLOT_LTAG    = 7;
    localparam int SLOT_BMASK   = 8;
    localparam int SLOT_BWIN    = 9;
    localparam int SLOT_PROT    = 10;
    localparam int SLOT_SCALARS = 11;

    // Byte offsets of the scalar words.
    localparam int OFS_CFG     = 'h000;
    localparam int OFS_BADADDR = 'h010;
    localparam int OFS_XBASE   = 'h018;
    localparam int OFS_XLIMIT  = 'h020;
    localparam int OFS_RFAULT  = 'h038;
    localparam int OFS_MFAULT  = 'h040;
    localparam int OFS_PTAG    = 'h048;
    localparam int OFS_LTAG    = 'h050;
    localparam int OFS_BMASK   = 'h058;
    localparam int OFS_BWIN    = 'h060;
    localparam int OFS_SPEED   = 'h070;
    localparam int OFS_DMA     = 'h100;
    localparam int OFS_PROT    = 'h220;
    localparam int WINDOW      = 'h300;
    localparam int ARR_STRIDE  = 8;

    localparam logic [WORD_W-1:0] CFG_RESET  = 32'h0000_0104;
    localparam logic [WORD_W-1:0] PROT_RESET = 32'h0000_0007;

    // Reset value of a given slot.
    function automatic logic [WORD_W-1:0] slot_reset(input int idx);
        if (idx == SLOT_CFG)  return CFG_RESET;
        if (idx == SLOT_PROT) return PROT_RESET;
        return '0;
    endfunction

endpackage

// File: rtl/chipreg_decode.sv
// Module: chipreg_decode
// Maps a byte offset to a storage slot. Reports whether the offset decodes,
// whether the slot accepts writes, and whether writes accumulate by OR.
// Assumes both arrays end below the decode window and that the array
// stride is 8 bytes, so odd words inside an array do not decode.
module chipreg_decode
    import chipreg_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int N_SPEED = 15,
    parameter int N_DMA   = 32,
    parameter int IDX_W   = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic              writable,
    output logic              accumulate
);
    localparam int SPEED_END  = OFS_SPEED + ARR_STRIDE * N_SPEED;
    localparam int DMA_END    = OFS_DMA + ARR_STRIDE * N_DMA;
    localparam int SPEED_SLOT = SLOT_SCALARS;
    localparam int DMA_SLOT   = SLOT_SCALARS + N_SPEED;
    localparam int STR_SHIFT  = $clog2(ARR_STRIDE);

    logic [ADDR_W-1:0] word_ofs;
    logic [ADDR_W-1:0] speed_rel;
    logic [ADDR_W-1:0] dma_rel;
    logic              in_speed;
    logic              in_dma;

    // Align the offset and form the array-relative offsets.
    always_comb begin
        word_ofs  = {addr[ADDR_W-1:2], 2'b00};
        speed_rel = word_ofs - ADDR_W'(OFS_SPEED);
        dma_rel   = word_ofs - ADDR_W'(OFS_DMA);
        in_speed  = (word_ofs >= ADDR_W'(OFS_SPEED)) && (word_ofs < ADDR_W'(SPEED_END))
                    && (word_ofs[2] == 1'b0);
        in_dma    = (word_ofs >= ADDR_W'(OFS_DMA)) && (word_ofs < ADDR_W'(DMA_END))
                    && (word_ofs[2] == 1'b0);
    end

    // Select the slot and its access attributes.
    always_comb begin
        hit        = 1'b1;
        writable   = 1'b1;
        accumulate = 1'b0;
        idx        = '0;
        if (in_speed) begin
            idx = IDX_W'(SPEED_SLOT) + IDX_W'(speed_rel >> STR_SHIFT);
        end else if (in_dma) begin
            idx = IDX_W'(DMA_SLOT) + IDX_W'(dma_rel >> STR_SHIFT);
        end else begin
            case (int'(word_ofs))
                OFS_CFG:     idx = IDX_W'(SLOT_CFG);
                OFS_BADADDR: begin idx = IDX_W'(SLOT_BADADDR); writable = 1'b0; end
                OFS_XBASE:   idx = IDX_W'(SLOT_XBASE);
                OFS_XLIMIT:  idx = IDX_W'(SLOT_XLIMIT);
                OFS_RFAULT:  begin idx = IDX_W'(SLOT_RFAULT); writable = 1'b0; end
                OFS_MFAULT:  begin idx = IDX_W'(SLOT_MFAULT); writable = 1'b0; end
                OFS_PTAG:    idx = IDX_W'(SLOT_PTAG);
                OFS_LTAG:    idx = IDX_W'(SLOT_LTAG);
                OFS_BMASK:   begin idx = IDX_W'(SLOT_BMASK); accumulate = 1'b1; end
                OFS_BWIN:    idx = IDX_W'(SLOT_BWIN);
                OFS_PROT:    idx = IDX_W'(SLOT_PROT);
                default: begin
                    hit      = 1'b0;
                    writable = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/chipreg_lane.sv
// Module: chipreg_lane
// Sub-word path. Builds the merged word for byte, halfword and word writes,
// either replacing or OR-accumulating the selected lanes. Also extracts the
// zero-extended lane for narrow reads. Assumes 32-bit words and narrow write
// data right-aligned on the bus.
module chipreg_lane
    import chipreg_pkg::*;
(
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] wdata,
    input  logic [1:0]        size,
    input  logic [1:0]        lane,
    input  logic              accumulate,
    output logic [WORD_W-1:0] new_word,
    output logic [WORD_W-1:0] rd_word
);
    logic [LANES-1:0]  be;
    logic [WORD_W-1:0] bit_mask;
    logic [WORD_W-1:0] placed;

    // Lane enables and replicated write data for the access width.
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: begin
                be     = LANES'(1) << lane;
                placed = {LANES{wdata[7:0]}};
            end
            SZ_HALF: begin
                be     = lane[1] ? 4'b1100 : 4'b0011;
                placed = {2{wdata[15:0]}};
            end
            default: begin
                be     = '1;
                placed = wdata;
            end
        endcase
    end

    // Expand the lane enables to a bit mask.
    for (genvar b = 0; b < LANES; b++) begin : g_mask
        assign bit_mask[8*b +: 8] = {8{be[b]}};
    end

    // Merge: replace the selected lanes, or OR into them.
    always_comb begin
        if (accumulate)
            new_word = old_word | (placed & bit_mask);
        else
            new_word = (old_word & ~bit_mask) | (placed & bit_mask);
    end

    // Read extraction, zero-extended.
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: rd_word = {24'b0, old_word[8*lane +: 8]};
            SZ_HALF: rd_word = {16'b0, (lane[1] ? old_word[31:16] : old_word[15:0])};
            default: rd_word = old_word;
        endcase
    end

endmodule

// File: rtl/chipreg_regfile.sv
// Module: chipreg_regfile
// Flat storage of all slots with a single write port. Each slot resets to
// its own value from slot_reset(). All slots are visible in parallel for
// read selection. Assumes at most one write per cycle.
module chipreg_regfile
    import chipreg_pkg::*;
#(
    parameter int NUM_SLOTS = 58,
    parameter int IDX_W     = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [IDX_W-1:0]                widx,
    input  logic [WORD_W-1:0]               wword,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0] q
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        // Slot i: load reset value or the merged write word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= slot_reset(i);
            else if (we && (widx == IDX_W'(i)))
                q[i] <= wword;
        end
    end

endmodule

// File: rtl/chipreg_bank.sv
// Module: chipreg_bank (top)
// Chipset control register bank on a single-cycle request bus. A write
// commits at the accepting edge. A read answers in the next cycle through
// a registered response. Assumes requests are one cycle wide and that
// N_DMA_REG is a power of two so a channel spans a contiguous slot run.
module chipreg_bank
    import chipreg_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int N_SPEED   = 15,
    parameter int N_DMA_CH  = 8,
    parameter int N_DMA_REG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    localparam int N_DMA     = N_DMA_CH * N_DMA_REG;
    localparam int NUM_SLOTS = SLOT_SCALARS + N_SPEED + N_DMA;
    localparam int IDX_W     = $clog2(NUM_SLOTS);

    logic                             dec_hit;
    logic [IDX_W-1:0]                 dec_idx;
    logic                             dec_wr_ok;
    logic                             dec_acc;
    logic [NUM_SLOTS-1:0][WORD_W-1:0] slot_q;
    logic [WORD_W-1:0]                cur_word;
    logic [WORD_W-1:0]                merged;
    logic [WORD_W-1:0]                lane_rd;
    logic                             do_write;
    logic                             do_read;
    logic [WORD_W-1:0]                cfg_q;
    logic [WORD_W-1:0]                nvprot_q;
    logic [WORD_W-1:0]                bmask_q;

    chipreg_decode #(
        .ADDR_W (ADDR_W),
        .N_SPEED(N_SPEED),
        .N_DMA  (N_DMA),
        .IDX_W  (IDX_W)
    ) u_decode (
        .addr      (bus_addr),
        .hit       (dec_hit),
        .idx       (dec_idx),
        .writable  (dec_wr_ok),
        .accumulate(dec_acc)
    );

    // Current contents of the addressed word; zero when undecoded.
    always_comb begin
        cur_word = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (dec_hit && (dec_idx == IDX_W'(i)))
                cur_word = slot_q[i];
        end
    end

    chipreg_lane u_lane (
        .old_word  (cur_word),
        .wdata     (bus_wdata),
        .size      (bus_size),
        .lane      (bus_addr[1:0]),
        .accumulate(dec_acc),
        .new_word  (merged),
        .rd_word   (lane_rd)
    );

    // Request qualification.
    always_comb begin
        do_write = bus_valid && bus_write && dec_hit && dec_wr_ok;
        do_read  = bus_valid && !bus_write;
    end

    chipreg_regfile #(
        .NUM_SLOTS(NUM_SLOTS),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (do_write),
        .widx (dec_idx),
        .wword(merged),
        .q    (slot_q)
    );

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= do_read;
            if (do_read)
                rsp_rdata <= lane_rd;
        end
    end

    // Named views of selected slots for the bound checker.
    always_comb begin
        cfg_q    = slot_q[SLOT_CFG];
        nvprot_q = slot_q[SLOT_PROT];
        bmask_q  = slot_q[SLOT_BMASK];
    end

endmodule

// File: rtl/chipreg_bank_chk.sv
// Module: chipreg_bank_chk
// Property checker bound to chipreg_bank. Watches the bus, the response
// and a few named slots.
module chipreg_bank_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic [31:0]       cfg_q,
    input logic [31:0]       nvprot_q,
    input logic [31:0]       bmask_q
);
    localparam int WIN = 'h300;

    assert_reset_values_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_q == 32'h104 && nvprot_q == 32'd7));

    assert_read_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rsp_valid);

    assert_no_spurious_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !rsp_valid);

    assert_byte_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_size == 2'd0) |=> (rsp_rdata[31:8] == 24'd0));

    assert_half_zext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_size == 2'd1) |=> (rsp_rdata[31:16] == 16'd0));

    assert_fault_regs_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write &&
         (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'('h38 >> 2) ||
          bus_addr[ADDR_W-1:2] == (ADDR_W-2)'('h40 >> 2) ||
          bus_addr[ADDR_W-1:2] == (ADDR_W-2)'('h10 >> 2))) |=> (rsp_rdata == 32'd0));

    assert_outside_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr >= ADDR_W'(WIN)) |=> (rsp_rdata == 32'd0));

    assert_mask_never_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bmask_q & $past(bmask_q)) == $past(bmask_q)));

endmodule

bind chipreg_bank chipreg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/chipreg_bank_tb.sv
// Directed bench for chipreg_bank: one task per scenario, each checking
// its own readbacks. Inputs are driven and outputs sampled on the falling edge.
module chipreg_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    int          n_checks = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    chipreg_bank u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        d = rsp_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [9:0] a, input logic [1:0] sz,
                          input logic [31:0] exp);
        logic [31:0] v;
        rd(a, sz, v);
        check(req, v, exp);
    endtask

    // R1: reset contents of every decoded word.
    task automatic t_reset;
        rd_chk("R1 cfg", 10'h000, 2'd2, 32'h104);
        rd_chk("R1 prot", 10'h220, 2'd2, 32'h7);
        rd_chk("R1 xbase", 10'h018, 2'd2, 32'h0);
        rd_chk("R1 bmask", 10'h058, 2'd2, 32'h0);
        for (int k = 0; k < 15; k++) rd_chk("R1 speed", 10'(10'h070 + 8*k), 2'd2, 32'h0);
        for (int k = 0; k < 32; k++) rd_chk("R1 dma", 10'(10'h100 + 8*k), 2'd2, 32'h0);
    endtask

    // R13, R2: response strobe timing.
    task automatic t_rsp;
        wr(10'h060, 2'd2, 32'h1);
        n_checks++;
        if (rsp_valid !== 1'b0) begin n_bad++; $display("FAIL R13: actual=%b expected=0", rsp_valid); end
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 10'h060; bus_size = 2'd2;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R2 rsp_valid", {31'b0, rsp_valid}, 32'h1);
        check("R2 data", rsp_rdata, 32'h1);
        @(negedge clk);
        check("R13 idle", {31'b0, rsp_valid}, 32'h0);
    endtask

    // R2, R3: scalar word map.
    task automatic t_scalars;
        wr(10'h000, 2'd2, 32'hC0F1_0001);
        wr(10'h018, 2'd2, 32'h1800_0018);
        wr(10'h020, 2'd2, 32'h2000_0020);
        wr(10'h048, 2'd2, 32'h4800_0048);
        wr(10'h050, 2'd2, 32'h5000_0050);
        wr(10'h060, 2'd2, 32'h6000_0060);
        wr(10'h220, 2'd3, 32'h2200_0220);
        rd_chk("R3 cfg", 10'h000, 2'd2, 32'hC0F1_0001);
        rd_chk("R3 xbase", 10'h018, 2'd2, 32'h1800_0018);
        rd_chk("R3 xlimit", 10'h020, 2'd2, 32'h2000_0020);
        rd_chk("R3 ptag", 10'h048, 2'd2, 32'h4800_0048);
        rd_chk("R3 ltag", 10'h050, 2'd2, 32'h5000_0050);
        rd_chk("R3 bwin", 10'h060, 2'd2, 32'h6000_0060);
        rd_chk("R3 prot", 10'h220, 2'd2, 32'h2200_0220);
    endtask

    // R4: remote-speed array.
    task automatic t_speed;
        for (int k = 0; k < 15; k++) wr(10'(10'h070 + 8*k), 2'd2, 32'hA000_0000 | k);
        for (int k = 0; k < 15; k++) rd_chk("R4 speed", 10'(10'h070 + 8*k), 2'd2, 32'hA000_0000 | k);
    endtask

    // R5: DMA channel array.
    task automatic t_dma;
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 4; r++)
                wr(10'(10'h100 + 32*c + 8*r), 2'd2, 32'hD000_0000 | (c << 8) | r);
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 4; r++)
                rd_chk("R5 dma", 10'(10'h100 + 32*c + 8*r), 2'd2, 32'hD000_0000 | (c << 8) | r);
    endtask

    // R6, R7: narrow reads.
    task automatic t_narrow_read;
        wr(10'h018, 2'd2, 32'h1122_3344);
        rd_chk("R6 lane0", 10'h018, 2'd0, 32'h44);
        rd_chk("R6 lane1", 10'h019, 2'd0, 32'h33);
        rd_chk("R6 lane2", 10'h01A, 2'd0, 32'h22);
        rd_chk("R6 lane3", 10'h01B, 2'd0, 32'h11);
        rd_chk("R7 low", 10'h018, 2'd1, 32'h3344);
        rd_chk("R7 high", 10'h01A, 2'd1, 32'h1122);
        rd_chk("R7 odd", 10'h01B, 2'd1, 32'h1122);
    endtask

    // R8: byte writes.
    task automatic t_byte_write;
        wr(10'h020, 2'd2, 32'hAABB_CCDD);
        wr(10'h022, 2'd0, 32'hFFFF_FF5E);
        rd_chk("R8 lane2", 10'h020, 2'd2, 32'hAA5E_CCDD);
        wr(10'h020, 2'd0, 32'h0000_0001);
        rd_chk("R8 lane0", 10'h020, 2'd2, 32'hAA5E_CC01);
        wr(10'h023, 2'd0, 32'h0000_0077);
        rd_chk("R8 lane3", 10'h020, 2'd2, 32'h775E_CC01);
    endtask

    // R9: halfword writes.
    task automatic t_half_write;
        wr(10'h048, 2'd2, 32'h1234_5678);
        wr(10'h04A, 2'd1, 32'h0000_BEEF);
        rd_chk("R9 upper", 10'h048, 2'd2, 32'hBEEF_5678);
        wr(10'h048, 2'd1, 32'hFFFF_CAFE);
        rd_chk("R9 lower", 10'h048, 2'd2, 32'hBEEF_CAFE);
    endtask

    // R10: cache byte mask accumulates.
    task automatic t_mask;
        wr(10'h058, 2'd2, 32'h0F00_0000);
        wr(10'h058, 2'd2, 32'h0000_00F0);
        rd_chk("R10 or", 10'h058, 2'd2, 32'h0F00_00F0);
        wr(10'h058, 2'd2, 32'h0);
        rd_chk("R10 zero", 10'h058, 2'd2, 32'h0F00_00F0);
        wr(10'h059, 2'd0, 32'h0000_000F);
        rd_chk("R10 byte", 10'h058, 2'd2, 32'h0F00_0FF0);
    endtask

    // R11: read-only fault words.
    task automatic t_readonly;
        wr(10'h010, 2'd2, 32'hFFFF_FFFF);
        wr(10'h038, 2'd2, 32'hFFFF_FFFF);
        wr(10'h040, 2'd0, 32'h0000_00FF);
        rd_chk("R11 badaddr", 10'h010, 2'd2, 32'h0);
        rd_chk("R11 rfault", 10'h038, 2'd2, 32'h0);
        rd_chk("R11 mfault", 10'h040, 2'd2, 32'h0);
    endtask

    // R12: undecoded offsets.
    task automatic t_undecoded;
        rd_chk("R12 gap", 10'h008, 2'd2, 32'h0);
        wr(10'h074, 2'd2, 32'hDEAD_BEEF);
        rd_chk("R12 odd speed", 10'h074, 2'd2, 32'h0);
        rd_chk("R12 speed0 kept", 10'h070, 2'd2, 32'hA000_0000);
        rd_chk("R12 speed1 kept", 10'h078, 2'd2, 32'hA000_0001);
        wr(10'h104, 2'd2, 32'hDEAD_BEEF);
        rd_chk("R12 odd dma", 10'h104, 2'd2, 32'h0);
        rd_chk("R12 dma kept", 10'h100, 2'd2, 32'hD000_0000);
        wr(10'h300, 2'd2, 32'hDEAD_BEEF);
        rd_chk("R12 above window", 10'h300, 2'd2, 32'h0);
        rd_chk("R12 cfg kept", 10'h000, 2'd2, 32'hC0F1_0001);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rsp();
        t_scalars();
        t_speed();
        t_dma();
        t_narrow_read();
        t_byte_write();
        t_half_write();
        t_mask();
        t_readonly();
        t_undecoded();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule